// File: doc/BRIEF.md
# Dual-Core Mailbox FIFO Pair

This block lets two processor cores in one clock domain pass 32-bit words to each other. It holds two independent queues of eight words each. One queue carries words from core 0 to core 1 and the other carries words from core 1 to core 0. Each core sees its own transmit queue and its own receive queue, and has a private status word and interrupt line.

A core sends a word by pulsing its push strobe with the data. It takes the oldest received word by pulsing its pop strobe. The word is presented on the read-data output during that same cycle and is removed at the clock edge.

The ready bit in the status word is the back-pressure signal. A push made while ready is low is not held back or stalled: it is dropped and recorded in a sticky overflow flag. A pop made while the valid bit is low returns zero and is recorded in a sticky read-on-empty flag. The interrupt line stays high while there is data to read or while either error flag is set. Software clears the error flags by writing 1s to the status word.

Top module: `mailbox_pair`

## Requirements
- R1: After synchronous reset, both queues are empty and all sticky flags are clear. Each status word reads 4'b0010 (valid 0, ready 1), each irq is 0 and each rx_data is 0.
- R2: Words pushed by one core reach the other core in push order, with all 32 bits intact. A core's own pushes never appear in its own receive queue.
- R3: Status bit 0 (valid) is 1 exactly when that core's receive queue holds at least one word.
- R4: Status bit 1 (ready) is 1 exactly when that core's transmit queue holds fewer than 8 words.
- R5: A push into a transmit queue that already holds 8 words is discarded, and the queue contents stay unchanged. Fullness is judged before any pop in the same cycle. The push sets status bit 2 (write overflow) of the pushing core.
- R6: A pop from an empty receive queue leaves the queue unchanged. rx_data reads 0 during that access, and the pop sets status bit 3 (read on empty) of that core.
- R7: A status write with stat_we clears bit 2 and/or bit 3 wherever stat_wdata holds a 1, and leaves a flag alone where it holds a 0. Bits 0 and 1 of the write have no effect. If a flag is set and cleared in the same cycle, the set wins.
- R8: Each core's irq equals the OR of its valid bit, its write-overflow flag and its read-on-empty flag.
- R9: A push and a pop on the same queue in the same cycle, with the queue neither full nor empty, are both honoured. The occupancy is unchanged and the order is kept.
- R10: While a core's receive queue is not empty, rx_data shows the oldest word. A pop consumes that word at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both cores |
| rst | input | 1 | Synchronous reset, active high |
| c0_tx_push | input | 1 | Core 0 push strobe |
| c0_tx_data | input | 32 | Core 0 word to send |
| c0_rx_pop | input | 1 | Core 0 pop strobe |
| c0_rx_data | output | 32 | Oldest word for core 0, or 0 when none is waiting |
| c0_stat_we | input | 1 | Core 0 status write strobe |
| c0_stat_wdata | input | 4 | Core 0 status write value (write 1 to clear bits 2 and 3) |
| c0_status | output | 4 | Core 0 status {roe, wof, ready, valid} |
| c0_irq | output | 1 | Core 0 interrupt |
| c1_tx_push | input | 1 | Core 1 push strobe |
| c1_tx_data | input | 32 | Core 1 word to send |
| c1_rx_pop | input | 1 | Core 1 pop strobe |
| c1_rx_data | output | 32 | Oldest word for core 1, or 0 when none is waiting |
| c1_stat_we | input | 1 | Core 1 status write strobe |
| c1_stat_wdata | input | 4 | Core 1 status write value (write 1 to clear bits 2 and 3) |
| c1_status | output | 4 | Core 1 status {roe, wof, ready, valid} |
| c1_irq | output | 1 | Core 1 interrupt |

## Verification
Short bursts of distinct words in each direction test ordering and direction separation. A swapped pointer or a crossed queue shows up as a wrong or missing word on the far core. Filling a queue to exactly eight words and then pushing a ninth separates the ready threshold from the drop behaviour: a ninth word that reaches the reader exposes a bad full check. Pops on an empty queue, push-plus-pop in one cycle, and clear writes that carry only read-only bits, or that coincide with a new error, each exercise one corner of the sticky-flag and occupancy logic.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int STAT_W   = 4;
  localparam int ST_VALID = 0;
  localparam int ST_READY = 1;
  localparam int ST_WOF   = 2;
  localparam int ST_ROE   = 3;
  localparam int NCORE    = 2;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R5
  drop_full_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> full);

  // R6
  pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> empty);

  // R9
  push_pop_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !full && !empty) |=> $stable(count));
endmodule

// File: rtl/mbox_status.sv
module mbox_status
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_push,
  input  logic              tx_full,
  input  logic              rx_pop,
  input  logic              rx_empty,
  input  logic              stat_we,
  input  logic [STAT_W-1:0] stat_wdata,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic wof, roe;
  logic wof_set, roe_set, wof_clr, roe_clr;

  assign wof_set = tx_push && tx_full;
  assign roe_set = rx_pop && rx_empty;
  assign wof_clr = stat_we && stat_wdata[ST_WOF];
  assign roe_clr = stat_we && stat_wdata[ST_ROE];

  always_ff @(posedge clk) begin
    if (rst) begin
      wof <= 1'b0;
      roe <= 1'b0;
    end else begin
      if (wof_set)      wof <= 1'b1;
      else if (wof_clr) wof <= 1'b0;
      if (roe_set)      roe <= 1'b1;
      else if (roe_clr) roe <= 1'b0;
    end
  end

  always_comb begin
    status           = '0;
    status[ST_VALID] = !rx_empty;
    status[ST_READY] = !tx_full;
    status[ST_WOF]   = wof;
    status[ST_ROE]   = roe;
  end

  assign irq = !rx_empty || wof || roe;

  // R5
  wof_set_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_push && tx_full) |=> wof);

  // R6
  roe_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_pop && rx_empty) |=> roe);

  // R7
  wof_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (wof && !(stat_we && stat_wdata[ST_WOF])) |=> wof);
endmodule

// File: rtl/mailbox_pair.sv
module mailbox_pair
  import mbox_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              c0_tx_push,
  input  logic [W-1:0]      c0_tx_data,
  input  logic              c0_rx_pop,
  output logic [W-1:0]      c0_rx_data,
  input  logic              c0_stat_we,
  input  logic [STAT_W-1:0] c0_stat_wdata,
  output logic [STAT_W-1:0] c0_status,
  output logic              c0_irq,
  input  logic              c1_tx_push,
  input  logic [W-1:0]      c1_tx_data,
  input  logic              c1_rx_pop,
  output logic [W-1:0]      c1_rx_data,
  input  logic              c1_stat_we,
  input  logic [STAT_W-1:0] c1_stat_wdata,
  output logic [STAT_W-1:0] c1_status,
  output logic              c1_irq
);
  logic              push  [NCORE];
  logic [W-1:0]      wdata [NCORE];
  logic              pop   [NCORE];
  logic              swe   [NCORE];
  logic [STAT_W-1:0] swd   [NCORE];
  logic [W-1:0]      head  [NCORE];
  logic              full  [NCORE];
  logic              empty [NCORE];
  logic [STAT_W-1:0] stat  [NCORE];
  logic              irq   [NCORE];

  assign push[0] = c0_tx_push;  assign push[1] = c1_tx_push;
  assign wdata[0] = c0_tx_data; assign wdata[1] = c1_tx_data;
  assign pop[0] = c0_rx_pop;    assign pop[1] = c1_rx_pop;
  assign swe[0] = c0_stat_we;   assign swe[1] = c1_stat_we;
  assign swd[0] = c0_stat_wdata; assign swd[1] = c1_stat_wdata;

  // Queue i is written by core i and read by the other core.
  for (genvar i = 0; i < NCORE; i++) begin : g_dir
    localparam int PEER = NCORE - 1 - i;

    mbox_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst       (rst),
      .push      (push[i]),
      .push_data (wdata[i]),
      .pop       (pop[PEER]),
      .head      (head[i]),
      .full      (full[i]),
      .empty     (empty[i])
    );

    mbox_status u_stat (
      .clk        (clk),
      .rst        (rst),
      .tx_push    (push[i]),
      .tx_full    (full[i]),
      .rx_pop     (pop[i]),
      .rx_empty   (empty[PEER]),
      .stat_we    (swe[i]),
      .stat_wdata (swd[i]),
      .status     (stat[i]),
      .irq        (irq[i])
    );

    // R8
    irq_on_data_chk: assert property (@(posedge clk) disable iff (rst)
      !empty[PEER] |-> irq[i]);
  end

  assign c0_rx_data = head[1];
  assign c1_rx_data = head[0];
  assign c0_status  = stat[0];
  assign c1_status  = stat[1];
  assign c0_irq     = irq[0];
  assign c1_irq     = irq[1];
endmodule

// File: tb/mailbox_pair_bench.sv
module mailbox_pair_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        c0_tx_push = 0, c0_rx_pop = 0, c0_stat_we = 0;
  logic        c1_tx_push = 0, c1_rx_pop = 0, c1_stat_we = 0;
  logic [31:0] c0_tx_data = 0, c1_tx_data = 0;
  logic [3:0]  c0_stat_wdata = 0, c1_stat_wdata = 0;
  logic [31:0] c0_rx_data, c1_rx_data;
  logic [3:0]  c0_status, c1_status;
  logic        c0_irq, c1_irq;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mailbox_pair u_mailbox_pair (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] st(input int c);
    return (c == 0) ? c0_status : c1_status;
  endfunction
  function automatic logic ir(input int c);
    return (c == 0) ? c0_irq : c1_irq;
  endfunction

  // All drives at negedge; the posedge in between commits them.
  task automatic push(input int c, input logic [31:0] d);
    @(negedge clk);
    if (c == 0) begin c0_tx_push = 1; c0_tx_data = d; end
    else        begin c1_tx_push = 1; c1_tx_data = d; end
    @(negedge clk);
    c0_tx_push = 0; c1_tx_push = 0;
  endtask

  task automatic pop(input int c, output logic [31:0] d);
    @(negedge clk);
    if (c == 0) c0_rx_pop = 1; else c1_rx_pop = 1;
    #1 d = (c == 0) ? c0_rx_data : c1_rx_data;
    @(negedge clk);
    c0_rx_pop = 0; c1_rx_pop = 0;
  endtask

  task automatic swrite(input int c, input logic [3:0] v);
    @(negedge clk);
    if (c == 0) begin c0_stat_we = 1; c0_stat_wdata = v; end
    else        begin c1_stat_we = 1; c1_stat_wdata = v; end
    @(negedge clk);
    c0_stat_we = 0; c1_stat_we = 0;
  endtask

  task automatic t_reset();
    chk("R1 c0 status", c0_status, 4'b0010);
    chk("R1 c1 status", c1_status, 4'b0010);
    chk("R1 irq", {c0_irq, c1_irq}, 0);
    chk("R1 rx_data", c0_rx_data | c1_rx_data, 0);
  endtask

  task automatic t_order();
    logic [31:0] d;
    push(0, 32'hA5A5_0001); push(0, 32'h5A5A_0002); push(0, 32'hFFFF_0003);
    chk("R3 c1 valid", st(1) & 4'b0001, 1);
    chk("R2 c0 own rx empty", st(0) & 4'b0001, 0);
    chk("R8 c1 irq on data", ir(1), 1);
    chk("R8 c0 irq idle", ir(0), 0);
    chk("R10 head shown", c1_rx_data, 32'hA5A5_0001);
    pop(1, d); chk("R2 word1", d, 32'hA5A5_0001);
    pop(1, d); chk("R2 word2", d, 32'h5A5A_0002);
    pop(1, d); chk("R2 word3", d, 32'hFFFF_0003);
    chk("R3 c1 empty again", st(1) & 4'b0001, 0);
  endtask

  task automatic t_full();
    logic [31:0] d;
    for (int k = 0; k < 7; k++) push(1, 32'h100 + k);
    chk("R4 ready at 7", st(1) & 4'b0010, 4'b0010);
    push(1, 32'h107);
    chk("R4 not ready at 8", st(1) & 4'b0010, 0);
    chk("R5 no wof yet", st(1) & 4'b0100, 0);
    push(1, 32'hDEAD);
    chk("R5 wof set", st(1) & 4'b0100, 4'b0100);
    chk("R8 irq on wof", ir(1), 1);
    for (int k = 0; k < 8; k++) begin
      pop(0, d); chk("R5 contents kept", d, 32'h100 + k);
    end
    chk("R5 dropped word absent", st(0) & 4'b0001, 0);
    swrite(1, 4'b0011);
    chk("R7 ro bits no clear", st(1) & 4'b0100, 4'b0100);
    swrite(1, 4'b0100);
    chk("R7 wof cleared", st(1), 4'b0010);
    chk("R8 irq low after clear", ir(1), 0);
  endtask

  task automatic t_empty_pop();
    logic [31:0] d;
    pop(0, d);
    chk("R6 zero data", d, 0);
    chk("R6 roe set", st(0), 4'b1010);
    chk("R8 irq on roe", ir(0), 1);
    swrite(0, 4'b0100);
    chk("R7 write 0 keeps roe", st(0) & 4'b1000, 4'b1000);
    // set and clear in the same cycle: set wins
    @(negedge clk);
    c0_rx_pop = 1; c0_stat_we = 1; c0_stat_wdata = 4'b1000;
    @(negedge clk);
    c0_rx_pop = 0; c0_stat_we = 0;
    chk("R7 set wins", st(0) & 4'b1000, 4'b1000);
    swrite(0, 4'b1000);
    chk("R7 roe cleared", st(0), 4'b0010);
  endtask

  task automatic t_push_pop();
    logic [31:0] d;
    push(0, 32'h11); push(0, 32'h22);
    @(negedge clk);
    c0_tx_push = 1; c0_tx_data = 32'h33; c1_rx_pop = 1;
    #1 d = c1_rx_data;
    @(negedge clk);
    c0_tx_push = 0; c1_rx_pop = 0;
    chk("R9 popped oldest", d, 32'h11);
    pop(1, d); chk("R9 second", d, 32'h22);
    pop(1, d); chk("R9 third", d, 32'h33);
    chk("R9 now empty", st(1) & 4'b0001, 0);
    chk("R9 no roe", st(1) & 4'b1000, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_order();
    t_full();
    t_empty_pop();
    t_push_pop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule